// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block gathers a set of peripheral interrupt inputs into a small number of interrupt lines, one per destination. Every source owns a pending flag, an enable flag and a capture mode. A level source keeps re-arming its pending flag for as long as its input stays high. An edge source arms its flag once per detected rising edge, falling edge or either edge. The pending flag stays set until software clears it.

Software reaches the block over a plain 32-bit register bus with separate request and write strobes. It can write the enable state in one go, or it can change single enables through a write-one-to-set alias and a write-one-to-clear alias. It selects the capture mode through two trigger registers. It acknowledges sources by writing ones to the pending register. For each destination, a read-only identity register shows which pending sources are also enabled. The destination's line stays high while that set is not empty.

Top module: `irq_sticky_agg`

## Requirements
- R1: Source n maps to bit n of every register. The byte offsets are: pending 0x10, enable 0x18, enable-clear 0x1C, enable-set 0x20, identity of destination d at 0x38+4*d, and trigger register t at 0x5C+4*t for t in {0,1}. Bits 31:24 and unmapped offsets read as zero and ignore writes.
- R2: Writing a 1 to a pending bit clears it and writing a 0 leaves it as it is. Without a write or a capture event, the pending bits hold their value.
- R3: A write to the enable offset replaces the whole enable set. A 1 written to enable-set turns that source on, and a 1 written to enable-clear turns it off. Zero bits in either alias change nothing.
- R4: A source with bit n clear in both trigger registers is level mode. It sets its pending bit on every cycle its synchronised input is high, so a clear issued while the input is high is overridden by the new set.
- R5: Edge encoding {trig1[n],trig0[n]}: 01 captures rising edges, 10 captures falling edges, 11 captures both. A detected edge sets the pending bit once.
- R6: The identity register of each destination reads pending AND enable. The destination's irq_o bit is high exactly when that value is non-zero.
- R7: After reset, the enable, pending and both trigger registers are zero, and every irq_o bit is low.
- R8: An input that changes before clock edge k shows up in the pending bit, and on irq_o, after edge k+2 (two synchroniser flops and then the pending flop). Read data appears after the clock edge at which the read request is sampled. A write takes effect at the edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Raw interrupt inputs, one per source |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | N_DST | Interrupt line per destination |

## Verification
Each result has a known latency. A change on an input shows in the pending bit and on irq_o after the third rising edge. The bench drives inputs on a falling edge, waits three rising edges and samples on the next falling edge. One dedicated check also samples after only two edges, to confirm the line is not high too early. Register reads are sampled on the falling edge after the rising edge that registered the data, and writes are checked with a read that starts on the falling edge after the write edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ENA     = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_ENA_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_ENA_SET = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_IDENT   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_TRIG    = 8'h5C;
  localparam int N_TRIG = 2;

  // mode = {trig1, trig0}
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import irq_agg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  trig_mode_e mode_i,
  output logic       set_o
);
  logic [2:0] sync_q;
  logic       cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], irq_i};
  end

  assign cur  = sync_q[1];
  assign prev = sync_q[2];

  always_comb begin
    unique case (mode_i)
      MODE_LEVEL: set_o = cur;
      MODE_RISE:  set_o = cur & ~prev;
      MODE_FALL:  set_o = ~cur & prev;
      MODE_BOTH:  set_o = cur ^ prev;
      default:    set_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 24,
  parameter int N_DST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  set_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic [N_SRC-1:0]  ena_o,
  output logic [N_SRC-1:0]  trig0_o,
  output logic [N_SRC-1:0]  trig1_o
);
  logic [N_SRC-1:0] pend_q, ena_q, ena_d, ident;
  logic [N_SRC-1:0] trig_q [N_TRIG];
  logic [N_SRC-1:0] wmask;
  logic             wr, rd;
  logic             wr_pend, wr_ena, wr_ena_clr, wr_ena_set;
  logic [N_TRIG-1:0] wr_trig;
  logic [DATA_W-1:0] rd_d;
  logic             unused_wdata;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wmask = wdata_i[N_SRC-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];

  assign wr_pend    = wr && (addr_i == OFF_PEND);
  assign wr_ena     = wr && (addr_i == OFF_ENA);
  assign wr_ena_clr = wr && (addr_i == OFF_ENA_CLR);
  assign wr_ena_set = wr && (addr_i == OFF_ENA_SET);

  for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
    assign wr_trig[t] = wr && (addr_i == ADDR_W'(OFF_TRIG + 4 * t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         trig_q[t] <= '0;
      else if (wr_trig[t]) trig_q[t] <= wmask;
    end
  end

  // capture events override a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(wr_pend ? wmask : '0)) | set_evt_i;
  end

  always_comb begin
    ena_d = ena_q;
    if (wr_ena)     ena_d = wmask;
    if (wr_ena_clr) ena_d = ena_q & ~wmask;
    if (wr_ena_set) ena_d = ena_q | wmask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ena_q <= '0;
    else         ena_q <= ena_d;
  end

  assign ident = pend_q & ena_q;

  always_comb begin
    rd_d = '0;
    unique case (addr_i)
      OFF_PEND: rd_d = DATA_W'(pend_q);
      OFF_ENA:  rd_d = DATA_W'(ena_q);
      default:  rd_d = '0;
    endcase
    for (int d = 0; d < N_DST; d++)
      if (addr_i == ADDR_W'(OFF_IDENT + 4 * d)) rd_d = DATA_W'(ident);
    for (int t = 0; t < N_TRIG; t++)
      if (addr_i == ADDR_W'(OFF_TRIG + 4 * t)) rd_d = DATA_W'(trig_q[t]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) rdata_o <= rd_d;
  end

  assign pend_o  = pend_q;
  assign ena_o   = ena_q;
  assign trig0_o = trig_q[0];
  assign trig1_o = trig_q[1];

  // R2: written ones clear unless re-armed in the same cycle
  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend |=> ((pend_q & $past(wmask & ~set_evt_i)) == '0));

  // R2: no write, no event -> pending holds
  a_r2_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && set_evt_i == '0) |=> $stable(pend_q));

  // R4: capture event wins over clear
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_evt_i != '0) |=> ((pend_q & $past(set_evt_i)) == $past(set_evt_i)));

  // R3: set alias
  a_r3_ena_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ena_set |=> ((ena_q & $past(wmask)) == $past(wmask)));

  // R3: clear alias
  a_r3_ena_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ena_clr |=> ((ena_q & $past(wmask)) == '0));
endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 24,
  parameter int N_DST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_DST-1:0]  irq_o
);
  logic [N_SRC-1:0] set_evt, pend, ena, trig0, trig1;
  logic             any_active;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    irq_src_capture u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i[n]),
      .mode_i (trig_mode_e'({trig1[n], trig0[n]})),
      .set_o  (set_evt[n])
    );
  end

  irq_agg_regs #(.N_SRC(N_SRC), .N_DST(N_DST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .set_evt_i (set_evt),
    .rdata_o   (bus_rdata_o),
    .pend_o    (pend),
    .ena_o     (ena),
    .trig0_o   (trig0),
    .trig1_o   (trig1)
  );

  assign any_active = |(pend & ena);

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    assign irq_o[d] = any_active;
  end

  // R6: identity read agrees with the line seen in the same cycle
  a_r6_ident_matches_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == OFF_IDENT)
      |=> ((bus_rdata_o != '0) == $past(irq_o[0])));
endmodule

// File: tb/irq_sticky_agg_bench.sv
`timescale 1ns/1ps
module irq_sticky_agg_bench;
  localparam int NS = 24;
  localparam int ND = 2;
  localparam logic [31:0] SRC_MASK = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [ND-1:0] irq_line;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_sticky_agg #(.N_SRC(NS), .N_DST(ND)) u_irq_sticky_agg (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq_line)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] lines(input logic [31:0] ident);
    return (ident != 0) ? 32'(2**ND - 1) : 32'h0;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_ena;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    check("R7 irq_o", 32'(irq_line), 0);
    rd_reg(8'h10, v); check("R7 pending", v, 0);
    rd_reg(8'h18, v); check("R7 enable", v, 0);
    rd_reg(8'h5C, v); check("R7 trig0", v, 0);
    rd_reg(8'h60, v); check("R7 trig1", v, 0);

    // R3 set alias sweep
    exp_ena = 0;
    for (int n = 0; n < NS; n++) begin
      wr_reg(8'h20, 32'h1 << n);
      exp_ena |= 32'h1 << n;
      rd_reg(8'h18, v); check("R3 enable-set", v, exp_ena);
    end
    // R1 upper bits ignored on direct write
    wr_reg(8'h18, 32'hFFFF_FFFF);
    rd_reg(8'h18, v); check("R1 upper bits", v, SRC_MASK);
    exp_ena = SRC_MASK;
    for (int n = 0; n < NS; n += 3) begin
      wr_reg(8'h1C, 32'h1 << n);
      exp_ena &= ~(32'h1 << n);
      rd_reg(8'h18, v); check("R3 enable-clear", v, exp_ena);
    end
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h18, v); check("R3 zero set no effect", v, exp_ena);
    wr_reg(8'h1C, 32'h0);
    rd_reg(8'h18, v); check("R3 zero clear no effect", v, exp_ena);
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18, v); check("R3 direct write zero", v, 0);

    // R1 unmapped offsets
    wr_reg(8'h40, 32'hFFFF_FFFF);
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_reg(8'h40, v); check("R1 unmapped read", v, 0);
    rd_reg(8'h14, v); check("R1 unmapped read", v, 0);
    rd_reg(8'h18, v); check("R1 unmapped write ignored", v, 0);

    // R8 latency, source 0 level
    wr_reg(8'h18, 32'h1);
    @(negedge clk);
    irq[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 not early", 32'(irq_line), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 due after third edge", 32'(irq_line), 32'h3);
    irq[0] = 1'b0;
    wait_cycles(3);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, v); check("R2 clear all", v, 0);

    // R4/R5/R2/R6 sweep over every source and mode
    wr_reg(8'h18, SRC_MASK);
    for (int n = 0; n < NS; n++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bit_n, e;
        bit_n = 32'h1 << n;
        wr_reg(8'h5C, m[0] ? bit_n : 32'h0);
        wr_reg(8'h60, m[1] ? bit_n : 32'h0);
        rd_reg(8'h5C, v); check("R1 trig0 readback", v, m[0] ? bit_n : 32'h0);
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h10, v); check("R2 cleared", v, 0);
        @(negedge clk); irq[n] = 1'b1;
        wait_cycles(3);
        e = (m != 2) ? bit_n : 32'h0;
        check("R5 R4 after rise", 32'(irq_line), lines(e));
        rd_reg(8'h10, v); check("R5 R4 pending after rise", v, e);
        rd_reg(8'h38, v); check("R6 ident0", v, e);
        wr_reg(8'h10, bit_n);
        e = (m == 0) ? bit_n : 32'h0;
        rd_reg(8'h10, v); check("R4 clear while high", v, e);
        @(negedge clk); irq[n] = 1'b0;
        wait_cycles(3);
        e = (m == 1) ? 32'h0 : bit_n;
        rd_reg(8'h10, v); check("R5 pending after fall", v, e);
        rd_reg(8'h3C, v); check("R6 ident1", v, e);
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h10, v); check("R2 final clear", v, 0);
      end
    end

    // R6 partial enable, all sources level
    wr_reg(8'h5C, 0);
    wr_reg(8'h60, 0);
    wr_reg(8'h18, 32'h00AA_AAAA);
    @(negedge clk); irq = '1;
    wait_cycles(3);
    rd_reg(8'h38, v); check("R6 ident0 masked", v, 32'h00AA_AAAA);
    rd_reg(8'h3C, v); check("R6 ident1 masked", v, 32'h00AA_AAAA);
    check("R6 lines high", 32'(irq_line), 32'h3);
    wr_reg(8'h18, 0);
    check("R6 lines low when disabled", 32'(irq_line), 0);
    rd_reg(8'h38, v); check("R6 ident empty", v, 0);
    rd_reg(8'h10, v); check("R2 pending kept", v, SRC_MASK);
    @(negedge clk); irq = '0;
    wait_cycles(3);
    wr_reg(8'h10, 32'h0000_00FF);
    rd_reg(8'h10, v); check("R2 partial clear", v, 32'h00FF_FF00);
    wait_cycles(2);
    rd_reg(8'h10, v); check("R2 holds", v, 32'h00FF_FF00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule